// File: doc/BRIEF.md
# Core Sampling Cache-Benefit Controller

This controller judges whether a throughput workload spread across many identical cores gains anything from the shared last-level cache. Two of the cores act as probes. One probe always bypasses the last-level cache, and the other always inserts its lines at the most-recently-used position. Over a programmable window the controller counts active cycles and retired instructions for each probe. It then compares the two throughput figures by cross-multiplication against a relative fixed-point threshold.

The outcome drives a one-bit "not cache-friendly" mask that a partitioning unit can consume. The same outcome sets the per-core policy selects: every core other than the two probes follows the verdict, bypassing when the workload is judged unfriendly and caching when it is judged friendly. Because the verdict comes from measured throughput rather than miss counts, a workload that misses often but hides the latency with parallelism is correctly classed as not needing cache space.

Top module: `cache_benefit_probe`

## Requirements
- R1: Bit BYP_IDX of `core_bypass` is always 1 (bypass) and bit MRU_IDX is always 0 (insert at MRU), whatever the verdict.
- R2: Every other bit of `core_bypass` equals `not_friendly`, so that exactly NUM_CORES-1 bits are set when the mask is 1 and exactly one bit is set when it is 0.
- R3: Reset clears `not_friendly` to 0 (cache-friendly), and it stays 0 until the first window has been evaluated.
- R4: A window lasts `window_len` cycles, or one cycle when `window_len` is 0. A probe's cycle and instruction counts grow only in cycles where its `*_active` input is 1, and `*_retire` is ignored in other cycles.
- R5: With Ib, Cb the bypass probe's instructions and active cycles and Im, Cm those of the caching probe, and T = `thresh_frac` / 2^FRAC_W, the workload is friendly only when Im*Cb*2^FRAC_W > (2^FRAC_W + `thresh_frac`)*Ib*Cm, that is when Im/Cm - Ib/Cb > T*Ib/Cb. Equality counts as unfriendly. `not_friendly` is the inverse of friendly.
- R6: When the caching probe is slower than the bypass probe (negative delta), the mask is 1 for any threshold.
- R7: `not_friendly` changes only on the clock edge one cycle after a window's final cycle, and it is stable in every other cycle.
- R8: A window in which either probe had zero active cycles leaves `not_friendly` unchanged.
- R9: All counts clear at each window end, so a verdict depends only on the window just finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| window_len | input | WIN_W | Sampling window length in cycles (0 behaves as 1) |
| thresh_frac | input | FRAC_W | Relative threshold, fraction of 2^FRAC_W |
| byp_active | input | 1 | Bypass probe core is active this cycle |
| byp_retire | input | RET_W | Instructions retired by the bypass probe this cycle |
| mru_active | input | 1 | Caching probe core is active this cycle |
| mru_retire | input | RET_W | Instructions retired by the caching probe this cycle |
| not_friendly | output | 1 | 1 when the workload is judged not cache-friendly |
| core_bypass | output | NUM_CORES | Per-core policy select: 1 bypass, 0 insert at MRU |

## Verification
A stuck or uncleared probe counter shows up as a wrong mask value one cycle after the window that follows the corruption, because the next verdict is computed from inflated totals. A window timer that is off by a cycle moves the mask edge away from the single legal update slot, and the stability property flags it at the first window end. An inverted or non-strict comparison appears at the equality boundary vectors, where a threshold one step apart must flip the mask. A wrong policy fanout appears at once as a `core_bypass` population count that disagrees with the mask.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

    typedef enum logic {
        POL_INSERT_MRU = 1'b0,
        POL_BYPASS     = 1'b1
    } llc_pol_e;

    typedef enum logic {
        VERDICT_FRIENDLY   = 1'b0,
        VERDICT_UNFRIENDLY = 1'b1
    } verdict_e;

    typedef enum logic [1:0] {
        ROLE_FOLLOWER   = 2'd0,
        ROLE_PROBE_BYP  = 2'd1,
        ROLE_PROBE_MRU  = 2'd2
    } core_role_e;

    // Role of a core given the two probe positions.
    function automatic core_role_e role_of(input int idx, input int byp_idx, input int mru_idx);
        if (idx == byp_idx)      return ROLE_PROBE_BYP;
        else if (idx == mru_idx) return ROLE_PROBE_MRU;
        else                     return ROLE_FOLLOWER;
    endfunction

    // Policy a core receives: probes are pinned, followers obey the verdict.
    function automatic llc_pol_e policy_for(input core_role_e role, input verdict_e v);
        case (role)
            ROLE_PROBE_BYP: return POL_BYPASS;
            ROLE_PROBE_MRU: return POL_INSERT_MRU;
            default:        return (v == VERDICT_UNFRIENDLY) ? POL_BYPASS : POL_INSERT_MRU;
        endcase
    endfunction

endpackage

// File: rtl/cbp_window_timer.sv
module cbp_window_timer #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIN_W-1:0] window_len,
    output logic             win_last
);
    logic [WIN_W-1:0] wcnt;
    logic [WIN_W-1:0] last_idx;

    // A zero length behaves as a single-cycle window.
    assign last_idx = (window_len == '0) ? '0 : window_len - 1'b1;
    // ">=" also closes a window at once if the length shrinks mid-window.
    assign win_last = !rst && (wcnt >= last_idx);

    always_ff @(posedge clk) begin
        if (rst)           wcnt <= '0;
        else if (win_last) wcnt <= '0;
        else               wcnt <= wcnt + 1'b1;
    end
endmodule

// File: rtl/cbp_perf_meter.sv
module cbp_perf_meter #(
    parameter int WIN_W = 16,
    parameter int RET_W = 3,
    localparam int IW   = WIN_W + RET_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [RET_W-1:0] retire,
    input  logic             clear,
    output logic [IW-1:0]    instr_tot,
    output logic [WIN_W-1:0] cyc_tot
);
    logic [IW-1:0]    instr_cnt;
    logic [WIN_W-1:0] cyc_cnt;

    // Totals include the current cycle so the window's last cycle counts.
    assign instr_tot = instr_cnt + (active ? IW'(retire) : '0);
    assign cyc_tot   = cyc_cnt + WIN_W'(active);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            instr_cnt <= '0;
            cyc_cnt   <= '0;
        end else begin
            instr_cnt <= instr_tot;
            cyc_cnt   <= cyc_tot;
        end
    end
endmodule

// File: rtl/cbp_verdict.sv
module cbp_verdict import cbp_pkg::*; #(
    parameter int WIN_W  = 16,
    parameter int RET_W  = 3,
    parameter int FRAC_W = 8,
    localparam int IW    = WIN_W + RET_W,
    localparam int CMP_W = IW + WIN_W + FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_last,
    input  logic [FRAC_W-1:0] thresh_frac,
    input  logic [IW-1:0]     byp_instr,
    input  logic [WIN_W-1:0]  byp_cyc,
    input  logic [IW-1:0]     mru_instr,
    input  logic [WIN_W-1:0]  mru_cyc,
    output logic              snap_vld,
    output logic              snap_empty,
    output verdict_e          verdict
);
    logic [IW-1:0]     s_ib, s_im;
    logic [WIN_W-1:0]  s_cb, s_cm;
    logic [FRAC_W:0]   scale;
    logic [CMP_W-1:0]  lhs, rhs;
    logic              friendly;

    // Stage 1: freeze the window totals.
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_vld <= 1'b0;
            s_ib <= '0; s_im <= '0; s_cb <= '0; s_cm <= '0;
        end else begin
            snap_vld <= win_last;
            if (win_last) begin
                s_ib <= byp_instr;
                s_cb <= byp_cyc;
                s_im <= mru_instr;
                s_cm <= mru_cyc;
            end
        end
    end

    // Stage 2: division-free comparison of the two throughputs.
    assign scale      = {1'b1, thresh_frac};
    assign lhs        = (CMP_W'(s_im) * CMP_W'(s_cb)) << FRAC_W;
    assign rhs        = CMP_W'(s_ib) * CMP_W'(s_cm) * CMP_W'(scale);
    assign friendly   = lhs > rhs;
    assign snap_empty = (s_cb == '0) || (s_cm == '0);

    always_ff @(posedge clk) begin
        if (rst)
            verdict <= VERDICT_FRIENDLY;
        else if (snap_vld && !snap_empty)
            verdict <= friendly ? VERDICT_FRIENDLY : VERDICT_UNFRIENDLY;
    end
endmodule

// File: rtl/cache_benefit_probe.sv
module cache_benefit_probe import cbp_pkg::*; #(
    parameter int NUM_CORES = 8,
    parameter int BYP_IDX   = 0,
    parameter int MRU_IDX   = 1,
    parameter int WIN_W     = 16,
    parameter int RET_W     = 3,
    parameter int FRAC_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WIN_W-1:0]     window_len,
    input  logic [FRAC_W-1:0]    thresh_frac,
    input  logic                 byp_active,
    input  logic [RET_W-1:0]     byp_retire,
    input  logic                 mru_active,
    input  logic [RET_W-1:0]     mru_retire,
    output logic                 not_friendly,
    output logic [NUM_CORES-1:0] core_bypass
);
    localparam int IW       = WIN_W + RET_W;
    localparam int N_PROBES = 2;   // index 0: bypass probe, index 1: caching probe

    logic                 win_last;
    logic                 snap_vld;
    logic                 snap_empty;
    verdict_e             verdict;
    logic [N_PROBES-1:0]  p_act;
    logic [RET_W-1:0]     p_ret   [N_PROBES];
    logic [IW-1:0]        p_instr [N_PROBES];
    logic [WIN_W-1:0]     p_cyc   [N_PROBES];

    assign p_act    = {mru_active, byp_active};
    assign p_ret[0] = byp_retire;
    assign p_ret[1] = mru_retire;

    cbp_window_timer #(.WIN_W(WIN_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .window_len (window_len),
        .win_last   (win_last)
    );

    for (genvar p = 0; p < N_PROBES; p++) begin : g_probe
        cbp_perf_meter #(.WIN_W(WIN_W), .RET_W(RET_W)) u_meter (
            .clk       (clk),
            .rst       (rst),
            .active    (p_act[p]),
            .retire    (p_ret[p]),
            .clear     (win_last),
            .instr_tot (p_instr[p]),
            .cyc_tot   (p_cyc[p])
        );
    end

    cbp_verdict #(.WIN_W(WIN_W), .RET_W(RET_W), .FRAC_W(FRAC_W)) u_verdict (
        .clk         (clk),
        .rst         (rst),
        .win_last    (win_last),
        .thresh_frac (thresh_frac),
        .byp_instr   (p_instr[0]),
        .byp_cyc     (p_cyc[0]),
        .mru_instr   (p_instr[1]),
        .mru_cyc     (p_cyc[1]),
        .snap_vld    (snap_vld),
        .snap_empty  (snap_empty),
        .verdict     (verdict)
    );

    assign not_friendly = (verdict == VERDICT_UNFRIENDLY);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        localparam core_role_e ROLE = role_of(c, BYP_IDX, MRU_IDX);
        assign core_bypass[c] = (policy_for(ROLE, verdict) == POL_BYPASS);
    end
endmodule

// File: rtl/cbp_checker.sv
module cbp_checker #(
    parameter int NUM_CORES = 8,
    parameter int BYP_IDX   = 0,
    parameter int MRU_IDX   = 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 win_last,
    input logic                 snap_vld,
    input logic                 snap_empty,
    input logic                 not_friendly,
    input logic [NUM_CORES-1:0] core_bypass
);
    p_probe_pins_r1: assert property (@(posedge clk) disable iff (rst)
        core_bypass[BYP_IDX] && !core_bypass[MRU_IDX]);

    p_follower_count_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(core_bypass) == (not_friendly ? NUM_CORES - 1 : 1));

    p_reset_clear_r3: assert property (@(posedge clk)
        rst |=> !not_friendly);

    p_snap_follows_last_r7: assert property (@(posedge clk) disable iff (rst)
        win_last |=> snap_vld);

    p_update_slot_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(snap_vld) |-> $stable(not_friendly));

    p_empty_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (snap_vld && snap_empty) |=> $stable(not_friendly));
endmodule

bind cache_benefit_probe cbp_checker #(
    .NUM_CORES (NUM_CORES),
    .BYP_IDX   (BYP_IDX),
    .MRU_IDX   (MRU_IDX)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .win_last     (win_last),
    .snap_vld     (snap_vld),
    .snap_empty   (snap_empty),
    .not_friendly (not_friendly),
    .core_bypass  (core_bypass)
);

// File: tb/cache_benefit_probe_tb.sv
module cache_benefit_probe_tb;
    localparam int NUM_CORES = 8;
    localparam int WIN_W     = 16;
    localparam int RET_W     = 3;
    localparam int FRAC_W    = 8;

    typedef struct packed {
        logic [15:0] len;
        logic [2:0]  rb;
        logic [2:0]  rm;
        logic        ab;
        logic        am;
        logic        mgap;   // caching probe idle on odd cycles, retire=7 then
        logic [7:0]  thr;
        logic        exp_mask;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'd8,  3'd4, 3'd2, 1'b1, 1'b1, 1'b0, 8'd0,   1'b1, 8'd6}, // R6 caching slower
        '{16'd8,  3'd2, 3'd4, 1'b1, 1'b1, 1'b0, 8'd64,  1'b0, 8'd9}, // R9 fresh counts give friendly
        '{16'd10, 3'd4, 3'd5, 1'b1, 1'b1, 1'b0, 8'd64,  1'b1, 8'd5}, // R5 exact equality
        '{16'd10, 3'd4, 3'd5, 1'b1, 1'b1, 1'b0, 8'd63,  1'b0, 8'd5}, // R5 one step below
        '{16'd5,  3'd3, 3'd3, 1'b1, 1'b1, 1'b0, 8'd0,   1'b1, 8'd5}, // R5 equal IPC, zero threshold
        '{16'd0,  3'd1, 3'd2, 1'b1, 1'b1, 1'b0, 8'd0,   1'b0, 8'd4}, // R4 zero length = one cycle
        '{16'd8,  3'd2, 3'd2, 1'b1, 1'b1, 1'b1, 8'd0,   1'b1, 8'd4}, // R4 inactive retire ignored
        '{16'd8,  3'd1, 3'd3, 1'b1, 1'b1, 1'b0, 8'd128, 1'b0, 8'd5}, // R5 large threshold passed
        '{16'd8,  3'd1, 3'd3, 1'b1, 1'b0, 1'b0, 8'd0,   1'b0, 8'd8}, // R8 caching probe idle
        '{16'd8,  3'd1, 3'd3, 1'b0, 1'b1, 1'b0, 8'd0,   1'b0, 8'd8}  // R8 bypass probe idle
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [WIN_W-1:0]     window_len = 16'd8;
    logic [FRAC_W-1:0]    thresh_frac = 8'd0;
    logic                 byp_active = 1'b0;
    logic [RET_W-1:0]     byp_retire = 3'd0;
    logic                 mru_active = 1'b0;
    logic [RET_W-1:0]     mru_retire = 3'd0;
    logic                 not_friendly;
    logic [NUM_CORES-1:0] core_bypass;

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    cache_benefit_probe #(
        .NUM_CORES(NUM_CORES), .BYP_IDX(0), .MRU_IDX(1),
        .WIN_W(WIN_W), .RET_W(RET_W), .FRAC_W(FRAC_W)
    ) u_dut (
        .clk(clk), .rst(rst), .window_len(window_len), .thresh_frac(thresh_frac),
        .byp_active(byp_active), .byp_retire(byp_retire),
        .mru_active(mru_active), .mru_retire(mru_retire),
        .not_friendly(not_friendly), .core_bypass(core_bypass)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [NUM_CORES-1:0] exp_pol(input logic m);
        return m ? 8'b1111_1101 : 8'b0000_0001;
    endfunction

    task automatic set_idle();
        byp_active = 1'b0; byp_retire = 3'd0;
        mru_active = 1'b0; mru_retire = 3'd0;
    endtask

    task automatic run_vec(input vec_t v);
        int n;
        logic prev;
        n = (v.len == 16'd0) ? 1 : int'(v.len);
        window_len  = v.len;
        thresh_frac = v.thr;
        prev = not_friendly;
        for (int k = 0; k < n; k++) begin
            byp_active = v.ab;
            byp_retire = v.rb;
            if (v.mgap && (k % 2 == 1)) begin
                mru_active = 1'b0;
                mru_retire = 3'd7;
            end else begin
                mru_active = v.am;
                mru_retire = v.rm;
            end
            @(negedge clk);
        end
        // Window closed at the last edge; verdict not yet updated (R7).
        check("R7 mask before update slot", 32'(not_friendly), 32'(prev));
        set_idle();
        @(negedge clk);
        check($sformatf("R%0d mask verdict", v.req), 32'(not_friendly), 32'(v.exp_mask));
        check("R1/R2 policy fanout R1 R2", 32'(core_bypass), 32'(exp_pol(v.exp_mask)));
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        set_idle();
        repeat (3) @(negedge clk);
        // R3: reset state
        check("R3 mask in reset", 32'(not_friendly), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R3 mask after reset", 32'(not_friendly), 32'd0);
        check("R1 policy after reset", 32'(core_bypass), 32'(exp_pol(1'b0)));
        // Resynchronise to a window start: reset again and release.
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R3: reset mid-operation returns to cache-friendly
        run_vec(VECS[0]);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R3 mask cleared by reset", 32'(not_friendly), 32'd0);
        check("R2 followers cleared by reset", 32'(core_bypass), 32'(exp_pol(1'b0)));
        rst = 1'b0;

        // R3: no verdict before the first window ends (idle-free active window)
        window_len = 16'd6; byp_active = 1'b1; byp_retire = 3'd5;
        mru_active = 1'b1; mru_retire = 3'd1;
        repeat (5) @(negedge clk);
        check("R3 mask before first window ends", 32'(not_friendly), 32'd0);
        @(negedge clk);
        set_idle();
        @(negedge clk);
        check("R6 first window verdict", 32'(not_friendly), 32'd1);

        finish_run();
    end
endmodule